// File: doc/BRIEF.md
# Tick-Driven Elapsed Timer with Match and Periodic Interrupts

This block keeps time for a small system from a slow counting strobe (nominally 32768 strobes per second) that arrives as a one-cycle enable in the core clock domain. It holds a 48-bit elapsed count that software may overwrite word by word to set the time. A 48-bit match value raises an interrupt when the count reaches it. Three periodic down-counters, each with a 32-bit reload, raise their own interrupts once per programmed period. Whole seconds are the count shifted right by 15.

All state is reached through a synchronous 16-bit port with a byte offset. Reads are combinational and return the live value of one word. No snapshot is taken across the words of a wide value, so software reads every word twice and accepts the result only when both passes agree. The four event sources share one status word whose bits are cleared by writing ones. Each status bit also drives its own interrupt line.

Top module: `rtt_timer_unit`

## Requirements
- R1: After reset every counter, match value, reload value and status bit is zero, so every readable word returns 0x0000 and `irq` is 0.
- R2: Each clock cycle with `tick` high and no write to a count word adds one to the 48-bit elapsed count, with carries across all three words. Without `tick` the count holds.
- R3: A write to offset 0x00 (bits 15:0), 0x02 (bits 31:16) or 0x04 (bits 47:32) replaces that word of the elapsed count. In a cycle that writes a count word, no increment takes place.
- R4: The match value lives at 0x08, 0x0A and 0x0C (low, middle, high). Status bit 0 sets on the clock edge at which a tick moves the elapsed count to a value equal to all 48 bits of the match value.
- R5: The status word at offset 0x3E holds bit 0 for the elapsed match, bits 1, 2 and 3 for periodic timers 0, 1 and 2, and reads zero in bits 15:4. A set bit stays set until a write with a 1 in that position. Writing 0 has no effect. `irq[i]` equals status bit i.
- R6: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Periodic timer k (k = 0, 1, 2) has its reload value at base+0x0 (bits 15:0) and base+0x2 (bits 31:16), and its current count at base+0x4 and base+0x6, with bases 0x10, 0x18 and 0x20. On a tick, a count of 0 loads the reload value, a count of 1 loads the reload value and sets the timer's status bit, and any other count decrements. A reload value of N therefore gives one event every N ticks.
- R8: A reload value of zero disables the timer. On every tick its count is forced to 0, and it never sets its status bit.
- R9: Offsets outside the map read 0x0000, and writes to them change no state. Address bit 0 is ignored.
- R10: `rdata` shows the addressed word of the current register state in the same cycle, with no read strobe and no latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle counting strobe |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 6 | Byte offset; bit 0 ignored |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| irq | output | 4 | Interrupt lines, one per status bit |

## Verification
The bench drives a tick into a count of 0x0000_FFFF_FFFF to expose a carry that stops at a 16-bit word boundary. It writes a count word on a tick cycle, where a design that increments anyway shows the low word off by one. It sets a match value that differs from the count only in the high word, so a design that compares only the low bits raises a false match. It counts the reload periods edge by edge, which catches a period that is off by one. A reload value that crosses the 16-bit boundary catches a broken borrow. A reload value of zero must stay silent. A clear that lands on the same edge as an event must not drop that event. Writes to unmapped offsets must leave every register unchanged.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned IDX_W    = ADDR_W - 1;
  localparam int unsigned CNT_W    = 48;
  localparam int unsigned RLD_W    = 32;
  localparam int unsigned N_PER    = 3;
  localparam int unsigned N_SRC    = N_PER + 1;
  // word indices (byte offset >> 1)
  localparam int unsigned CNT_IDX  = 0;
  localparam int unsigned MCH_IDX  = 4;
  localparam int unsigned PER_IDX  = 8;
  localparam int unsigned PER_STEP = 4;
  localparam int unsigned STAT_IDX = 31;

  typedef enum logic [1:0] {
    SRC_MATCH = 2'd0,
    SRC_PER0  = 2'd1,
    SRC_PER1  = 2'd2,
    SRC_PER2  = 2'd3
  } src_e;
endpackage

// File: rtl/rtt_rst_sync.sv
module rtt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rtt_elapsed.sv
module rtt_elapsed #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic [CNT_W/WORD_W-1:0] cnt_we_i,
  input  logic [CNT_W/WORD_W-1:0] mch_we_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [CNT_W-1:0]      mch_o,
  output logic                  match_o
);
  localparam int unsigned NW = CNT_W / WORD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mch_q, mch_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             any_cnt_we;

  assign any_cnt_we = |cnt_we_i;
  assign cnt_inc    = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    mch_d = mch_q;
    if (any_cnt_we) begin
      for (int w = 0; w < NW; w++) begin
        if (cnt_we_i[w]) cnt_d[w*WORD_W +: WORD_W] = wdata_i;
      end
    end else if (tick_i) begin
      cnt_d = cnt_inc;
    end
    for (int w = 0; w < NW; w++) begin
      if (mch_we_i[w]) mch_d[w*WORD_W +: WORD_W] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mch_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      mch_q <= mch_d;
    end
  end

  assign match_o = tick_i && !any_cnt_we && (cnt_inc == mch_q);
  assign cnt_o   = cnt_q;
  assign mch_o   = mch_q;

  // R2: a tick without a count write advances the count by one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !any_cnt_we) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R2: without a tick and without a write the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !any_cnt_we) |=> (cnt_q == $past(cnt_q)));
  // R4: a match event leaves the count equal to the match value
  a_r4_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !(|mch_we_i)) |=> (cnt_q == mch_q));
endmodule

// File: rtl/rtt_period.sv
module rtt_period #(
  parameter int unsigned RLD_W  = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic [RLD_W/WORD_W-1:0] rld_we_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [RLD_W-1:0]        rld_o,
  output logic [RLD_W-1:0]        cur_o,
  output logic                    evt_o
);
  localparam int unsigned NW = RLD_W / WORD_W;

  logic [RLD_W-1:0] rld_q, rld_d;
  logic [RLD_W-1:0] cur_q, cur_d;
  logic             enabled;

  assign enabled = (rld_q != '0);

  always_comb begin
    rld_d = rld_q;
    for (int w = 0; w < NW; w++) begin
      if (rld_we_i[w]) rld_d[w*WORD_W +: WORD_W] = wdata_i;
    end
  end

  always_comb begin
    cur_d = cur_q;
    if (tick_i) begin
      if (!enabled)                  cur_d = '0;
      else if (cur_q <= RLD_W'(1))   cur_d = rld_q;
      else                           cur_d = cur_q - RLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      cur_q <= '0;
    end else begin
      rld_q <= rld_d;
      cur_q <= cur_d;
    end
  end

  assign evt_o = tick_i && enabled && (cur_q == RLD_W'(1));
  assign rld_o = rld_q;
  assign cur_o = cur_q;

  // R8: a zero reload forces the count to zero on a tick
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rld_q == '0) |=> (cur_q == '0));
  // R7: an event reloads the count from the reload value
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> (cur_q == $past(rld_q)));
  // R7: the count only moves on a tick
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> (cur_q == $past(cur_q)));
endmodule

// File: rtl/rtt_timer_unit.sv
module rtt_timer_unit
  import rtt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [N_SRC-1:0]  irq
);
  localparam int unsigned CNT_NW = CNT_W / WORD_W;
  localparam int unsigned RLD_NW = RLD_W / WORD_W;

  logic             rst_i_n;
  logic [IDX_W-1:0] widx;
  logic [CNT_NW-1:0] cnt_we, mch_we;
  logic [CNT_W-1:0] cnt_val, mch_val;
  logic             match_evt;
  logic [RLD_W-1:0] per_rld [N_PER];
  logic [RLD_W-1:0] per_cur [N_PER];
  logic [N_PER-1:0] per_evt;
  logic [N_SRC-1:0] stat_q, stat_d, stat_set, stat_clr;

  assign widx = addr[ADDR_W-1:1];

  rtt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  genvar gw;
  generate
    for (gw = 0; gw < CNT_NW; gw++) begin : g_cnt_we
      assign cnt_we[gw] = wr_en && (widx == IDX_W'(CNT_IDX + gw));
      assign mch_we[gw] = wr_en && (widx == IDX_W'(MCH_IDX + gw));
    end
  endgenerate

  rtt_elapsed #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_elapsed (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick_i   (tick),
    .cnt_we_i (cnt_we),
    .mch_we_i (mch_we),
    .wdata_i  (wdata),
    .cnt_o    (cnt_val),
    .mch_o    (mch_val),
    .match_o  (match_evt)
  );

  genvar gp, gr;
  generate
    for (gp = 0; gp < N_PER; gp++) begin : g_per
      logic [RLD_NW-1:0] rld_we;
      for (gr = 0; gr < RLD_NW; gr++) begin : g_we
        assign rld_we[gr] = wr_en &&
          (widx == IDX_W'(PER_IDX + gp*PER_STEP + gr));
      end
      rtt_period #(.RLD_W(RLD_W), .WORD_W(WORD_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .tick_i   (tick),
        .rld_we_i (rld_we),
        .wdata_i  (wdata),
        .rld_o    (per_rld[gp]),
        .cur_o    (per_cur[gp]),
        .evt_o    (per_evt[gp])
      );
    end
  endgenerate

  // status: events set, write-one clears, set wins
  assign stat_set = {per_evt, match_evt};
  assign stat_clr = (wr_en && widx == IDX_W'(STAT_IDX)) ? wdata[N_SRC-1:0] : '0;

  always_comb begin
    stat_d = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) stat_q <= '0;
    else          stat_q <= stat_d;
  end

  assign irq = stat_q;

  // read mux
  always_comb begin
    rdata = '0;
    for (int w = 0; w < CNT_NW; w++) begin
      if (widx == IDX_W'(CNT_IDX + w)) rdata = cnt_val[w*WORD_W +: WORD_W];
      if (widx == IDX_W'(MCH_IDX + w)) rdata = mch_val[w*WORD_W +: WORD_W];
    end
    for (int p = 0; p < N_PER; p++) begin
      for (int w = 0; w < RLD_NW; w++) begin
        if (widx == IDX_W'(PER_IDX + p*PER_STEP + w))
          rdata = per_rld[p][w*WORD_W +: WORD_W];
        if (widx == IDX_W'(PER_IDX + p*PER_STEP + RLD_NW + w))
          rdata = per_cur[p][w*WORD_W +: WORD_W];
      end
    end
    if (widx == IDX_W'(STAT_IDX)) rdata = {{(WORD_W-N_SRC){1'b0}}, stat_q};
  end

  // R6: an event always lands in the status word
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|stat_set) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));
  // R5: set bits that are not cleared stay set
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~stat_clr)) == $past(stat_q & ~stat_clr)));
  // R5: a clear without a coincident event empties the bit
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|(stat_clr & ~stat_set)) |=> ((stat_q & $past(stat_clr & ~stat_set)) == '0));
  // R8: a disabled timer never raises an event
  a_r8_no_evt: assert property (@(posedge clk) disable iff (!rst_i_n)
    (per_rld[0] == '0) |-> !per_evt[0]);
endmodule

// File: tb/rtt_timer_unit_bench.sv
`timescale 1ns/1ps
module rtt_timer_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [5:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtt_timer_unit u_rtt_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic with_tick = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd48(input logic [5:0] base, output logic [47:0] v);
    logic [15:0] l, m, h;
    rd(base, l); rd(base + 6'd2, m); rd(base + 6'd4, h);
    v = {h, m, l};
  endtask

  task automatic rd32(input logic [5:0] base, output logic [31:0] v);
    logic [15:0] l, h;
    rd(base, l); rd(base + 6'd2, h);
    v = {h, l};
  endtask

  task automatic set48(input logic [5:0] base, input logic [47:0] v);
    wr(base, v[15:0]); wr(base + 6'd2, v[31:16]); wr(base + 6'd4, v[47:32]);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 64; a += 2) begin
      rd(6'(a), d);
      check($sformatf("R1 reset word 0x%0h", a), d, 0);
    end
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_count;
    logic [47:0] v;
    ticks(7);
    rd48(6'h00, v);
    check("R2 seven ticks", v, 48'd7);
    repeat (3) @(negedge clk);
    rd48(6'h00, v);
    check("R2 hold without tick", v, 48'd7);
    set48(6'h00, 48'h0000_FFFF_FFFF);
    rd48(6'h00, v);
    check("R3 word writes", v, 48'h0000_FFFF_FFFF);
    ticks(1);
    rd48(6'h00, v);
    check("R2 carry across words", v, 48'h0001_0000_0000);
    rd48(6'h01, v);
    check("R9 address bit 0 ignored", v, 48'h0001_0000_0000);
  endtask

  task automatic t_write_vs_tick;
    logic [47:0] v;
    wr(6'h00, 16'h1234, 1'b1);
    rd48(6'h00, v);
    check("R3 write suppresses tick", v, 48'h0001_0000_1234);
  endtask

  task automatic t_match;
    logic [15:0] s;
    set48(6'h00, 48'd0);
    set48(6'h08, 48'd5);
    ticks(4);
    rd(6'h3E, s);
    check("R4 no match before", s[0], 1'b0);
    ticks(1);
    rd(6'h3E, s);
    check("R4 match at compare value", s[0], 1'b1);
    check("R5 irq0 follows status", irq[0], 1'b1);
    ticks(2);
    wr(6'h3E, 16'h0000);
    rd(6'h3E, s);
    check("R5 stays set, zero write ignored", s[0], 1'b1);
    wr(6'h3E, 16'h0001);
    rd(6'h3E, s);
    check("R5 write one clears", s, 16'h0000);
    check("R5 irq0 drops", irq[0], 1'b0);
    set48(6'h00, 48'd0);
    set48(6'h08, 48'h0001_0000_0005);
    ticks(8);
    rd(6'h3E, s);
    check("R4 high word must match too", s[0], 1'b0);
  endtask

  task automatic t_period;
    logic [31:0] c;
    logic [15:0] s;
    set48(6'h00, 48'd0);
    wr(6'h10, 16'd3); wr(6'h12, 16'd0);
    ticks(1);
    rd32(6'h14, c);
    check("R7 first tick loads reload", c, 32'd3);
    ticks(2);
    rd32(6'h14, c);
    check("R7 decrement", c, 32'd1);
    rd(6'h3E, s);
    check("R7 no event before period", s[1], 1'b0);
    ticks(1);
    rd(6'h3E, s);
    check("R7 event on reaching one", s[1], 1'b1);
    check("R5 irq1", irq[1], 1'b1);
    rd32(6'h14, c);
    check("R7 reload after event", c, 32'd3);
    wr(6'h3E, 16'h0002);
    ticks(2);
    rd(6'h3E, s);
    check("R7 period not early", s[1], 1'b0);
    ticks(1);
    rd(6'h3E, s);
    check("R7 period of three ticks", s[1], 1'b1);
    wr(6'h10, 16'd0);
    ticks(1);
    rd32(6'h14, c);
    check("R8 zero reload forces zero", c, 32'd0);
    wr(6'h3E, 16'h0002);
    ticks(5);
    rd(6'h3E, s);
    check("R8 disabled timer silent", s[1], 1'b0);
    wr(6'h18, 16'd0); wr(6'h1A, 16'd1);
    ticks(1);
    rd32(6'h1C, c);
    check("R7 wide reload", c, 32'h0001_0000);
    ticks(1);
    rd32(6'h1C, c);
    check("R7 borrow across words", c, 32'h0000_FFFF);
    rd(6'h3E, s);
    check("R7 timer1 no event yet", s[2], 1'b0);
    wr(6'h1A, 16'd0);
    ticks(1);
    rd32(6'h1C, c);
    check("R8 timer1 disabled", c, 32'd0);
  endtask

  task automatic t_set_wins;
    logic [15:0] s;
    wr(6'h20, 16'd1);
    ticks(1);
    rd(6'h3E, s);
    check("R7 timer2 loaded, no event", s[3], 1'b0);
    wr(6'h3E, 16'h0008, 1'b1);
    rd(6'h3E, s);
    check("R6 event beats clear", s[3], 1'b1);
    wr(6'h3E, 16'h0008);
    rd(6'h3E, s);
    check("R6 plain clear", s[3], 1'b0);
    wr(6'h20, 16'd0);
    ticks(1);
    wr(6'h3E, 16'h000F);
  endtask

  task automatic t_reserved;
    logic [47:0] c0, c1, m0, m1;
    logic [15:0] s0, s1, d;
    rd48(6'h00, c0); rd48(6'h08, m0); rd(6'h3E, s0);
    wr(6'h06, 16'hFFFF); wr(6'h0E, 16'hFFFF);
    wr(6'h28, 16'hFFFF); wr(6'h3C, 16'hFFFF);
    rd(6'h06, d); check("R9 reserved 0x06 reads zero", d, 0);
    rd(6'h28, d); check("R9 reserved 0x28 reads zero", d, 0);
    rd(6'h3C, d); check("R9 reserved 0x3C reads zero", d, 0);
    rd48(6'h00, c1); rd48(6'h08, m1); rd(6'h3E, s1);
    check("R9 count untouched", c1, c0);
    check("R9 match untouched", m1, m0);
    check("R9 status untouched", s1, s0);
    check("R10 irq idle", irq, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count();
    t_write_vs_tick();
    t_match();
    t_period();
    t_set_wins();
    t_reserved();
    finish_run();
  end
endmodule